// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup with Ring ASIDs

This block turns a 32-bit virtual address into a physical address by searching a small set-associative translation buffer. There are two separate buffers, one for instruction fetches and one for data accesses, and each has several ways. Every way has its own fixed page size. In each way the address selects one entry, and all ways are compared in parallel within the same cycle. An entry hits only when three things hold: its page number matches the address, its address-space tag is nonzero, and that tag appears in one of the four byte slots of a ring-tag register. The slot where the tag is found gives the ring of the page.

The lookup is combinational. For a single hit that passes the checks, the block returns the physical address, the page size, the effective read, write and execute rights, and a cache-mode code. Otherwise it returns a fault cause code. Entries are loaded through a one-cycle write port. The ring-tag register is loaded through its own write strobe. Page-table walking happens elsewhere. The cache mode is only reported.

Top module: `tlb_xlate`

## Requirements
- R1: After reset the ring-tag register holds 0x04030201, so the tag in byte k gives ring k. Every entry is invalid, so all lookups miss until an entry is written.
- R2: A lookup hits an entry when four conditions hold: the entry is the one the address indexes in that way, the page numbers match, the tag is nonzero, and the tag equals some byte of the ring-tag register. The ring of the hit is the lowest byte index that matches.
- R3: An entry whose tag is zero, or whose tag is in no byte of the ring-tag register, never hits.
- R4: Two or more hitting ways give cause 2 on the instruction side and cause 6 on the data side.
- R5: No hit gives cause 1 on the instruction side and cause 5 on the data side. Cause 0 means success.
- R6: A hit whose ring is numerically lower than the current ring input gives cause 3 (instruction) or 7 (data).
- R7: Attribute values below 12 grant read. Attribute bit 0 adds execute and bit 1 adds write. Bits [3:2] equal to 0, 1 or 2 give cache code 1 (bypass), 2 (write-back) or 3 (write-through). Attribute 13 grants read and write with cache code 4 (isolate). Every other value grants nothing and gives cache code 0.
- R8: The data side removes execute and the instruction side removes read and write. The access kind (0 read, 1 write, 2 execute) is then checked against what remains. A denial gives cause 4 on the instruction side, and on the data side cause 9 for a write or cause 8 otherwise. The rights stay visible on a denial.
- R9: Way w uses page shift BASE_SHIFT + w*SHIFT_STEP. The page size is 1 shifted left by that shift. The physical address is the entry's page base ORed with the address bits below the shift.
- R10: A write to the ring-tag register changes the ring mapping from the next cycle on.
- R11: Entry writes go only to the side selected for the write. The other side is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rasid_we | input | 1 | Load the ring-tag register |
| rasid_wdata | input | 32 | New ring-tag value, ring k in byte k |
| wr_en | input | 1 | Write an entry |
| wr_dside | input | 1 | Entry write side: 1 data, 0 instruction |
| wr_way | input | $clog2(NWAYS) | Way to write |
| wr_idx | input | IDXW | Entry index within the way |
| wr_vpn | input | 32 | Virtual page base (masked to the way's page) |
| wr_ppn | input | 32 | Physical page base (masked to the way's page) |
| wr_asid | input | 8 | Address-space tag, 0 means invalid |
| wr_attr | input | 4 | Attribute code |
| lk_va | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_dside | input | 1 | Lookup side: 1 data, 0 instruction |
| lk_ring | input | 2 | Current privilege ring |
| xl_cause | output | 4 | Fault cause, 0 on success |
| xl_pa | output | 32 | Physical address, 0 unless cause is 0 |
| xl_page_size | output | 32 | Page size in bytes, 0 unless cause is 0 |
| xl_can_read | output | 1 | Effective read right of the hit entry |
| xl_can_write | output | 1 | Effective write right of the hit entry |
| xl_can_exec | output | 1 | Effective execute right of the hit entry |
| xl_cache | output | 3 | Cache-mode code of the hit entry |

## Verification
Some relations hold on every cycle and the bound checker watches them continuously. Success implies exactly one hit and a power-of-two page size. Two or more hits force the multi-hit cause, and zero hits force the miss cause. A privilege fault implies the hit ring is below the current ring. The side stripping of rights is never violated. The ring-tag register takes the written value, and nothing hits before the first entry write. The bench scenarios are needed for everything else: the actual address arithmetic for each way's page size, the attribute decode values, which tags fall outside the ring register, the isolation between the two sides, and the reset value of the ring mapping.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W = 32;

  localparam logic [3:0] C_OK         = 4'd0;
  localparam logic [3:0] C_I_MISS     = 4'd1;
  localparam logic [3:0] C_I_MULTI    = 4'd2;
  localparam logic [3:0] C_I_PRIV     = 4'd3;
  localparam logic [3:0] C_I_DENY     = 4'd4;
  localparam logic [3:0] C_D_MISS     = 4'd5;
  localparam logic [3:0] C_D_MULTI    = 4'd6;
  localparam logic [3:0] C_D_PRIV     = 4'd7;
  localparam logic [3:0] C_LOAD_DENY  = 4'd8;
  localparam logic [3:0] C_STORE_DENY = 4'd9;

  localparam logic [2:0] CM_NONE    = 3'd0;
  localparam logic [2:0] CM_BYPASS  = 3'd1;
  localparam logic [2:0] CM_WBACK   = 3'd2;
  localparam logic [2:0] CM_WTHRU   = 3'd3;
  localparam logic [2:0] CM_ISOLATE = 3'd4;

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_EXEC  = 2'd2;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    logic [2:0] cm;
  } rights_t;

  // {found, ring}: lowest byte index whose tag equals asid
  function automatic logic [2:0] ring_lookup(input logic [7:0] asid,
                                             input logic [31:0] rasid);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 3; i >= 0; i--) begin
      if (rasid[i*8 +: 8] == asid) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

  function automatic rights_t decode_attr(input logic [3:0] a);
    rights_t r;
    r = '0;
    if (a < 4'd12) begin
      r.rd = 1'b1;
      r.ex = a[0];
      r.wr = a[1];
      case (a[3:2])
        2'd0:    r.cm = CM_BYPASS;
        2'd1:    r.cm = CM_WBACK;
        2'd2:    r.cm = CM_WTHRU;
        default: r.cm = CM_NONE;
      endcase
    end else if (a == 4'd13) begin
      r.rd = 1'b1;
      r.wr = 1'b1;
      r.cm = CM_ISOLATE;
    end
    return r;
  endfunction

  function automatic logic [31:0] page_mask(input int shift);
    return ~((32'h1 << shift) - 32'h1);
  endfunction

  function automatic logic [31:0] page_bytes(input int shift);
    return 32'h1 << shift;
  endfunction
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import tlbx_pkg::*;
#(
  parameter int NWAYS      = 4,
  parameter int IDXW       = 2,
  parameter int BASE_SHIFT = 12,
  parameter int SHIFT_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NWAYS)-1:0] wr_way,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [31:0]              wr_vpn,
  input  logic [31:0]              wr_ppn,
  input  logic [7:0]               wr_asid,
  input  logic [3:0]               wr_attr,
  input  logic [31:0]              lk_va,
  input  logic [31:0]              rasid,
  output logic [NWAYS-1:0]         way_hit,
  output logic [NWAYS*2-1:0]       way_ring,
  output logic [NWAYS*32-1:0]      way_ppn,
  output logic [NWAYS*4-1:0]       way_attr
);
  localparam int ENTRIES = 1 << IDXW;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    localparam int SH = BASE_SHIFT + w * SHIFT_STEP;
    logic [31:0] vpn_q  [ENTRIES];
    logic [31:0] ppn_q  [ENTRIES];
    logic [7:0]  asid_q [ENTRIES];
    logic [3:0]  attr_q [ENTRIES];
    logic        sel_w;
    logic [IDXW-1:0] idx;
    logic [2:0]  rmatch;

    assign sel_w = wr_en && (wr_way == w[$clog2(NWAYS)-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++) begin
          vpn_q[e]  <= '0;
          ppn_q[e]  <= '0;
          asid_q[e] <= '0;
          attr_q[e] <= '0;
        end
      end else if (sel_w) begin
        vpn_q[wr_idx]  <= wr_vpn & page_mask(SH);
        ppn_q[wr_idx]  <= wr_ppn & page_mask(SH);
        asid_q[wr_idx] <= wr_asid;
        attr_q[wr_idx] <= wr_attr;
      end
    end

    assign idx    = lk_va[SH +: IDXW];
    assign rmatch = ring_lookup(asid_q[idx], rasid);

    assign way_hit[w] = (vpn_q[idx] == (lk_va & page_mask(SH))) &&
                        (asid_q[idx] != 8'd0) && rmatch[2];
    assign way_ring[w*2 +: 2]  = rmatch[1:0];
    assign way_ppn[w*32 +: 32] = ppn_q[idx];
    assign way_attr[w*4 +: 4]  = attr_q[idx];
  end
endmodule

// File: rtl/tlb_hit_resolve.sv
module tlb_hit_resolve #(
  parameter int NWAYS = 4
) (
  input  logic [NWAYS-1:0]               way_hit,
  input  logic [NWAYS*2-1:0]             way_ring,
  input  logic [NWAYS*32-1:0]            way_ppn,
  input  logic [NWAYS*4-1:0]             way_attr,
  output logic [$clog2(NWAYS+1)-1:0]     hit_cnt,
  output logic [$clog2(NWAYS)-1:0]       hit_way,
  output logic [1:0]                     hit_ring,
  output logic [31:0]                    hit_ppn,
  output logic [3:0]                     hit_attr
);
  localparam int CW = $clog2(NWAYS + 1);
  localparam int WW = $clog2(NWAYS);

  always_comb begin
    hit_cnt  = '0;
    hit_way  = '0;
    hit_ring = '0;
    hit_ppn  = '0;
    hit_attr = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (way_hit[w]) begin
        hit_cnt  = hit_cnt + CW'(1);
        hit_way  = WW'(w);
        hit_ring = way_ring[w*2 +: 2];
        hit_ppn  = way_ppn[w*32 +: 32];
        hit_attr = way_attr[w*4 +: 4];
      end
    end
  end
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlbx_pkg::*;
#(
  parameter int NWAYS      = 4,
  parameter int BASE_SHIFT = 12,
  parameter int SHIFT_STEP = 4
) (
  input  logic [$clog2(NWAYS+1)-1:0] hit_cnt,
  input  logic [$clog2(NWAYS)-1:0]   hit_way,
  input  logic [1:0]                 hit_ring,
  input  logic [31:0]                hit_ppn,
  input  logic [3:0]                 hit_attr,
  input  logic [31:0]                lk_va,
  input  logic [1:0]                 lk_kind,
  input  logic                       lk_dside,
  input  logic [1:0]                 lk_ring,
  output logic [3:0]                 cause,
  output logic [31:0]                pa,
  output logic [31:0]                page_size,
  output rights_t                    rights
);
  int          sh;
  rights_t     raw;
  logic        grant;

  always_comb begin
    sh  = BASE_SHIFT + int'(hit_way) * SHIFT_STEP;
    raw = decode_attr(hit_attr);
    if (lk_dside) raw.ex = 1'b0;
    else begin
      raw.rd = 1'b0;
      raw.wr = 1'b0;
    end
    case (lk_kind)
      K_READ:  grant = raw.rd;
      K_WRITE: grant = raw.wr;
      K_EXEC:  grant = raw.ex;
      default: grant = 1'b0;
    endcase

    cause     = C_OK;
    pa        = '0;
    page_size = '0;
    rights    = '0;
    if (hit_cnt == '0) begin
      cause = lk_dside ? C_D_MISS : C_I_MISS;
    end else if (hit_cnt > 1) begin
      cause = lk_dside ? C_D_MULTI : C_I_MULTI;
    end else if (hit_ring < lk_ring) begin
      cause = lk_dside ? C_D_PRIV : C_I_PRIV;
    end else begin
      rights = raw;
      if (!grant) begin
        if (!lk_dside)               cause = C_I_DENY;
        else if (lk_kind == K_WRITE) cause = C_STORE_DENY;
        else                         cause = C_LOAD_DENY;
      end else begin
        pa        = hit_ppn | (lk_va & ~page_mask(sh));
        page_size = page_bytes(sh);
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlbx_pkg::*;
#(
  parameter int NWAYS      = 4,
  parameter int IDXW       = 2,
  parameter int BASE_SHIFT = 12,
  parameter int SHIFT_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rasid_we,
  input  logic [31:0]              rasid_wdata,
  input  logic                     wr_en,
  input  logic                     wr_dside,
  input  logic [$clog2(NWAYS)-1:0] wr_way,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [31:0]              wr_vpn,
  input  logic [31:0]              wr_ppn,
  input  logic [7:0]               wr_asid,
  input  logic [3:0]               wr_attr,
  input  logic [31:0]              lk_va,
  input  logic [1:0]               lk_kind,
  input  logic                     lk_dside,
  input  logic [1:0]               lk_ring,
  output logic [3:0]               xl_cause,
  output logic [31:0]              xl_pa,
  output logic [31:0]              xl_page_size,
  output logic                     xl_can_read,
  output logic                     xl_can_write,
  output logic                     xl_can_exec,
  output logic [2:0]               xl_cache
);
  localparam int CW = $clog2(NWAYS + 1);
  localparam int WW = $clog2(NWAYS);
  localparam logic [31:0] RASID_RST = 32'h0403_0201;

  logic [31:0] rasid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        rasid_q <= RASID_RST;
    else if (rasid_we) rasid_q <= rasid_wdata;
  end

  logic [NWAYS-1:0]    s_hit  [2];
  logic [NWAYS*2-1:0]  s_ring [2];
  logic [NWAYS*32-1:0] s_ppn  [2];
  logic [NWAYS*4-1:0]  s_attr [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    tlb_way_bank #(
      .NWAYS(NWAYS), .IDXW(IDXW),
      .BASE_SHIFT(BASE_SHIFT), .SHIFT_STEP(SHIFT_STEP)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_dside == s[0])),
      .wr_way   (wr_way),
      .wr_idx   (wr_idx),
      .wr_vpn   (wr_vpn),
      .wr_ppn   (wr_ppn),
      .wr_asid  (wr_asid),
      .wr_attr  (wr_attr),
      .lk_va    (lk_va),
      .rasid    (rasid_q),
      .way_hit  (s_hit[s]),
      .way_ring (s_ring[s]),
      .way_ppn  (s_ppn[s]),
      .way_attr (s_attr[s])
    );
  end

  logic [CW-1:0] hit_cnt;
  logic [WW-1:0] hit_way;
  logic [1:0]    hit_ring;
  logic [31:0]   hit_ppn;
  logic [3:0]    hit_attr;
  rights_t       rights;

  tlb_hit_resolve #(.NWAYS(NWAYS)) u_resolve (
    .way_hit  (s_hit[lk_dside]),
    .way_ring (s_ring[lk_dside]),
    .way_ppn  (s_ppn[lk_dside]),
    .way_attr (s_attr[lk_dside]),
    .hit_cnt  (hit_cnt),
    .hit_way  (hit_way),
    .hit_ring (hit_ring),
    .hit_ppn  (hit_ppn),
    .hit_attr (hit_attr)
  );

  tlb_perm_check #(
    .NWAYS(NWAYS), .BASE_SHIFT(BASE_SHIFT), .SHIFT_STEP(SHIFT_STEP)
  ) u_check (
    .hit_cnt   (hit_cnt),
    .hit_way   (hit_way),
    .hit_ring  (hit_ring),
    .hit_ppn   (hit_ppn),
    .hit_attr  (hit_attr),
    .lk_va     (lk_va),
    .lk_kind   (lk_kind),
    .lk_dside  (lk_dside),
    .lk_ring   (lk_ring),
    .cause     (xl_cause),
    .pa        (xl_pa),
    .page_size (xl_page_size),
    .rights    (rights)
  );

  assign xl_can_read  = rights.rd;
  assign xl_can_write = rights.wr;
  assign xl_can_exec  = rights.ex;
  assign xl_cache     = rights.cm;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlbx_pkg::*;
#(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rasid_we,
  input logic [31:0]   rasid_wdata,
  input logic [31:0]   rasid_q,
  input logic          lk_dside,
  input logic [1:0]    lk_ring,
  input logic [CW-1:0] hit_cnt,
  input logic [1:0]    hit_ring,
  input logic [3:0]    xl_cause,
  input logic [31:0]   xl_page_size,
  input logic          xl_can_read,
  input logic          xl_can_write,
  input logic          xl_can_exec
);
  logic seen_wr;
  always_ff @(posedge clk) begin
    if (!rst_n)     seen_wr <= 1'b0;
    else if (wr_en) seen_wr <= 1'b1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> hit_cnt == '0);

  // R2
  ok_one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_cause == C_OK |-> hit_cnt == CW'(1));

  // R4
  multi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt > CW'(1) |-> xl_cause == (lk_dside ? C_D_MULTI : C_I_MULTI));

  // R5
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt == '0 |-> xl_cause == (lk_dside ? C_D_MISS : C_I_MISS));

  // R6
  priv_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_cause == C_D_PRIV || xl_cause == C_I_PRIV) |-> hit_ring < lk_ring);

  // R8
  strip_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dside |-> !xl_can_exec);

  // R8
  strip_inst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_dside |-> !xl_can_read && !xl_can_write);

  // R9
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_cause == C_OK |-> $countones(xl_page_size) == 1);

  // R10
  rasid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rasid_we |=> rasid_q == $past(rasid_wdata));
endmodule

bind tlb_xlate tlb_xlate_chk #(.CW($clog2(NWAYS + 1))) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rasid_we     (rasid_we),
  .rasid_wdata  (rasid_wdata),
  .rasid_q      (rasid_q),
  .lk_dside     (lk_dside),
  .lk_ring      (lk_ring),
  .hit_cnt      (hit_cnt),
  .hit_ring     (hit_ring),
  .xl_cause     (xl_cause),
  .xl_page_size (xl_page_size),
  .xl_can_read  (xl_can_read),
  .xl_can_write (xl_can_write),
  .xl_can_exec  (xl_can_exec)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rasid_we = 1'b0;
  logic [31:0] rasid_wdata = '0;
  logic        wr_en = 1'b0;
  logic        wr_dside = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0;
  logic [31:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic [31:0] lk_va = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_dside = 1'b0;
  logic [1:0]  lk_ring = '0;
  logic [3:0]  xl_cause;
  logic [31:0] xl_pa;
  logic [31:0] xl_page_size;
  logic        xl_can_read;
  logic        xl_can_write;
  logic        xl_can_exec;
  logic [2:0]  xl_cache;

  always #5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
    .wr_en(wr_en), .wr_dside(wr_dside), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .lk_va(lk_va), .lk_kind(lk_kind), .lk_dside(lk_dside), .lk_ring(lk_ring),
    .xl_cause(xl_cause), .xl_pa(xl_pa), .xl_page_size(xl_page_size),
    .xl_can_read(xl_can_read), .xl_can_write(xl_can_write),
    .xl_can_exec(xl_can_exec), .xl_cache(xl_cache)
  );

  typedef struct {
    logic [3:0]  cause;
    logic [31:0] pa;
    logic [31:0] size;
    logic        r, w, x;
    logic [2:0]  cm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  function automatic exp_t mk(string tag, logic [3:0] cause, logic [31:0] pa,
                              logic [31:0] size, logic r, logic w, logic x,
                              logic [2:0] cm);
    exp_t e;
    e.tag = tag; e.cause = cause; e.pa = pa; e.size = size;
    e.r = r; e.w = w; e.x = x; e.cm = cm;
    return e;
  endfunction

  // monitor: compares at the falling edge, after the driver set inputs
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (xl_cause !== e.cause || xl_pa !== e.pa || xl_page_size !== e.size ||
          xl_can_read !== e.r || xl_can_write !== e.w ||
          xl_can_exec !== e.x || xl_cache !== e.cm) begin
        errors++;
        $display("FAIL %s: got cause=%0d pa=%h size=%h rwx=%b%b%b cm=%0d, expected cause=%0d pa=%h size=%h rwx=%b%b%b cm=%0d",
                 e.tag, xl_cause, xl_pa, xl_page_size, xl_can_read,
                 xl_can_write, xl_can_exec, xl_cache, e.cause, e.pa, e.size,
                 e.r, e.w, e.x, e.cm);
      end
    end
  end

  task automatic put_entry(bit ds, int way, int idx, logic [31:0] vpn,
                           logic [31:0] ppn, logic [7:0] asid, logic [3:0] attr);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_dside = ds; wr_way = 2'(way); wr_idx = 2'(idx);
    wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_rasid(logic [31:0] v);
    @(posedge clk); #1;
    rasid_we = 1'b1; rasid_wdata = v;
    @(posedge clk); #1;
    rasid_we = 1'b0;
  endtask

  task automatic probe(logic [31:0] va, logic [1:0] kind, bit ds,
                       logic [1:0] ring, exp_t e);
    @(posedge clk); #1;
    lk_va = va; lk_kind = kind; lk_dside = ds; lk_ring = ring;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    probe(32'h0000_1000, 2'd0, 1, 2'd0, mk("R1 data miss after reset", 4'd5, 0, 0, 0, 0, 0, 0));
    probe(32'h0000_1000, 2'd2, 0, 2'd0, mk("R1 inst miss after reset", 4'd1, 0, 0, 0, 0, 0, 0));

    // R2: single hit in way 0, 4 KiB page, attr 7
    put_entry(1, 0, 1, 32'h0000_1000, 32'h8000_0000, 8'd1, 4'd7);
    probe(32'h0000_1234, 2'd0, 1, 2'd0, mk("R2 data read hit", 4'd0, 32'h8000_0234, 32'h1000, 1, 1, 0, 3'd2));
    // R11: instruction side untouched
    probe(32'h0000_1234, 2'd2, 0, 2'd0, mk("R11 inst side unaffected", 4'd1, 0, 0, 0, 0, 0, 0));
    // R8: execute on data side stripped -> load denied
    probe(32'h0000_1234, 2'd2, 1, 2'd0, mk("R8 data exec denied", 4'd8, 0, 0, 1, 1, 0, 3'd2));
    // R6: ring 0 page seen from ring 1
    probe(32'h0000_1234, 2'd0, 1, 2'd1, mk("R6 data privilege", 4'd7, 0, 0, 0, 0, 0, 0));

    // R9: way 1 (64 KiB), tag 3 -> ring 2
    put_entry(1, 1, 3, 32'h0023_0000, 32'h1234_0000, 8'd3, 4'd1);
    probe(32'h0023_ABCD, 2'd0, 1, 2'd2, mk("R9 way1 64K page", 4'd0, 32'h1234_ABCD, 32'h0001_0000, 1, 0, 0, 3'd1));
    probe(32'h0023_ABCD, 2'd1, 1, 2'd2, mk("R8 store denied", 4'd9, 0, 0, 1, 0, 0, 3'd1));

    // R7/R9: inst way 2 (1 MiB), attr 9 write-through exec
    put_entry(0, 2, 1, 32'h0450_0000, 32'h00F0_0000, 8'd4, 4'd9);
    probe(32'h045A_BCDE, 2'd2, 0, 2'd3, mk("R7 inst exec WT", 4'd0, 32'h00FA_BCDE, 32'h0010_0000, 0, 0, 1, 3'd3));
    probe(32'h045A_BCDE, 2'd0, 0, 2'd3, mk("R8 inst read denied", 4'd4, 0, 0, 0, 0, 1, 3'd3));

    // R7: attr 13 isolate in way 3 (16 MiB)
    put_entry(1, 3, 2, 32'h2A00_0000, 32'h5000_0000, 8'd2, 4'd13);
    probe(32'h2A12_3456, 2'd1, 1, 2'd0, mk("R7 isolate write", 4'd0, 32'h5012_3456, 32'h0100_0000, 1, 1, 0, 3'd4));
    put_entry(1, 3, 2, 32'h2A00_0000, 32'h5000_0000, 8'd2, 4'd12);
    probe(32'h2A12_3456, 2'd0, 1, 2'd0, mk("R7 attr 12 grants nothing", 4'd8, 0, 0, 0, 0, 0, 3'd0));

    // R3: tag outside ring register, and tag zero
    put_entry(1, 0, 2, 32'h0000_2000, 32'h0, 8'h55, 4'd7);
    probe(32'h0000_2000, 2'd0, 1, 2'd0, mk("R3 foreign tag misses", 4'd5, 0, 0, 0, 0, 0, 0));
    put_entry(1, 0, 3, 32'h0000_3000, 32'h0, 8'h00, 4'd7);
    probe(32'h0000_3000, 2'd0, 1, 2'd0, mk("R3 zero tag misses", 4'd5, 0, 0, 0, 0, 0, 0));

    // R4: second hit for 0x1234 in way 1
    put_entry(1, 1, 0, 32'h0000_0000, 32'h0, 8'd2, 4'd3);
    probe(32'h0000_1234, 2'd0, 1, 2'd0, mk("R4 data multi-hit", 4'd6, 0, 0, 0, 0, 0, 0));

    // R10: remap rings: byte0=04 byte1=03 byte2=02 byte3=01
    set_rasid(32'h0102_0304);
    probe(32'h045A_BCDE, 2'd2, 0, 2'd3, mk("R10 inst now ring0", 4'd3, 0, 0, 0, 0, 0, 0));
    probe(32'h0023_ABCD, 2'd0, 1, 2'd2, mk("R10 data now ring1", 4'd7, 0, 0, 0, 0, 0, 0));
    probe(32'h0023_ABCD, 2'd0, 1, 2'd1, mk("R10 data ring1 ok", 4'd0, 32'h1234_ABCD, 32'h0001_0000, 1, 0, 0, 3'd1));

    // R1: reset again clears entries and restores ring mapping
    do_reset();
    probe(32'h0023_ABCD, 2'd0, 1, 2'd0, mk("R1 entries cleared", 4'd5, 0, 0, 0, 0, 0, 0));
    put_entry(1, 0, 1, 32'h0000_1000, 32'h8000_0000, 8'd4, 4'd7);
    probe(32'h0000_1234, 2'd0, 1, 2'd3, mk("R1 tag 4 is ring 3", 4'd0, 32'h8000_0234, 32'h1000, 1, 1, 0, 3'd2));

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule